// File: doc/BRIEF.md
# High-Resolution Delayed Compare Output

This block drives one output pin with timing finer than the loop period. A loop is a fixed run of high-resolution (HR) periods. It has lr periods, with lr a power of two from 1 to 128. A one-cycle `loop_start` pulse marks the first cycle of each loop. During a loop, logic that runs at the loop rate may present a compare event. The event carries a target pin level and a 7-bit delay field. The block then moves the pin to that level on the clock edge where the HR tick (`hr_en`) is high and the HR phase counter equals the decoded delay.

The delay field is read as a binary fraction of the loop, with the most significant bit first. Bit 6 is worth half a loop and bit 0 is worth 1/128 of a loop. When the loop is shorter than 128 HR periods, the low bits that cannot be resolved count as zero. Each loop accepts at most one event. Any further event in the same loop is dropped, and a sticky overrun flag is raised. An accepted event that has not matched by the next loop boundary is discarded.

The HR tick, the HR phase and the loop size are all supplied from outside. The loop size is given as `lr_log2`, which is log2(lr). It is assumed to stay constant within a loop.

Top module: `hr_delay_out`

## Requirements
- R1: While reset is active (`rst_n` low at a clock edge), and on the cycle after it, `pin` reads 0 and `overrun` reads 0.
- R2: With `lr_log2` = 7 (lr = 128), take an event accepted in a loop with delay field D in 0..127. The pin is driven to the event level on the edge where `hr_en` = 1 and `hr_phase` = D, and reads that level from the next cycle on.
- R3: With lr = 2^L (L = `lr_log2`), the effective delay in HR periods is D >> (7 − L). D[6] weighs half a loop, D[5] a quarter, and so on down to D[0] at 1/128. The low 7 − L bits of D have no effect on when the pin changes.
- R4: With `lr_log2` = 0 (lr = 1), the effective delay is 0 for every D. An event presented together with `loop_start` changes the pin on that same edge.
- R5: The pin changes only on edges where `hr_en` = 1. A phase equal to the delay while `hr_en` = 0 triggers nothing.
- R6: Once an event has been accepted in a loop, every later `evt_valid` in that loop is ignored, so the pin never takes its level. The first such ignored event makes `overrun` read 1 from the next cycle.
- R7: Once set, `overrun` stays 1 through all later loops until reset.
- R8: If an accepted event has not matched by the next `loop_start`, it is discarded and the pin keeps its level. This covers an event whose delay had already passed when it arrived.
- R9: `loop_start` reopens acceptance. An event presented in the same cycle as `loop_start` belongs to the new loop and is accepted without setting `overrun`.
- R10: The first event of a loop may arrive after `loop_start`. It is applied if its phase is still ahead within that loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hr_en | input | 1 | HR tick: high on edges where the HR phase is valid to act on |
| hr_phase | input | 7 | HR phase counter within the current loop |
| lr_log2 | input | 3 | log2 of HR periods per loop (0..7) |
| loop_start | input | 1 | One-cycle pulse on the first cycle of each loop |
| evt_valid | input | 1 | Compare event presented this cycle |
| evt_level | input | 1 | Target pin level of the event |
| evt_delay | input | 7 | MSB-aligned fractional delay field |
| pin | output | 1 | Driven pin level |
| overrun | output | 1 | Sticky: a second event arrived within one loop |

## Verification
The pin change is registered once, on the edge where `hr_en` is high and the phase matches. The new level is therefore due one cycle after the matching phase is presented. `overrun` is likewise due one cycle after the ignored event. The bench keeps a behavioural model, updated on the rising edge from the same inputs the design samples. The bench compares `pin` and `overrun` against that model on every falling edge, before it drives the next inputs, so each result is checked in exactly the cycle it is due. Scenario checks after key edges cover the moment of each edge: the cycle before the match, the cycle after it, and the next loop boundary.

// File: rtl/hrdo_pkg.sv
// Shared defaults for the HR delayed compare output.
// Assumes the delay field width is a small power-of-two exponent (lr <= 2^HR_W).
package hrdo_pkg;
    // Width of the fractional delay field and of the HR phase counter.
    localparam int HRDO_FIELD_W = 7;
    // Width needed to encode log2(lr) in 0..HRDO_FIELD_W.
    localparam int HRDO_LRL_W   = $clog2(HRDO_FIELD_W + 1);
    // Reset level of the driven pin.
    localparam logic HRDO_PIN_INIT = 1'b0;
endpackage

// File: rtl/hrdo_field_decode.sv
// Turns the MSB-aligned fractional delay field into a delay in HR periods.
// For lr = 2^L the delay is field >> (HR_W - L); the low bits lr cannot
// resolve drop out. Pure combinational; assumes lr_log2 <= HR_W. Larger codes
// decode to zero.
module hrdo_field_decode #(
    parameter int HR_W  = hrdo_pkg::HRDO_FIELD_W,
    parameter int LRL_W = hrdo_pkg::HRDO_LRL_W
) (
    input  logic [HR_W-1:0]  field,
    input  logic [LRL_W-1:0] lr_log2,
    output logic [HR_W-1:0]  delay
);
    localparam int NCAND = HR_W + 1;

    logic [HR_W-1:0] cand [NCAND];

    // One shifted candidate per supported loop size.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        if (k == 0) begin : g_zero
            assign cand[k] = '0;
        end else begin : g_shift
            assign cand[k] = field >> (HR_W - k);
        end
    end

    // Select the candidate matching the present loop size.
    always_comb begin
        delay = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (lr_log2 == LRL_W'(k)) begin
                delay = cand[k];
            end
        end
    end
endmodule

// File: rtl/hrdo_phase_cmp.sv
// Compares the HR phase against two decoded delays: the one arriving this
// cycle and the one held pending. A hit only counts on an HR tick.
// Assumes both delays are already decoded to HR periods.
module hrdo_phase_cmp #(
    parameter int HR_W = hrdo_pkg::HRDO_FIELD_W
) (
    input  logic            hr_en,
    input  logic [HR_W-1:0] hr_phase,
    input  logic [HR_W-1:0] new_dly,
    input  logic [HR_W-1:0] pend_dly,
    output logic            hit_new,
    output logic            hit_pend
);
    localparam int NCMP = 2;

    logic [HR_W-1:0] ref_dly [NCMP];
    logic [NCMP-1:0] hit;

    assign ref_dly[0] = new_dly;
    assign ref_dly[1] = pend_dly;

    // One equality comparator per delay source.
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign hit[i] = hr_en && (hr_phase == ref_dly[i]);
    end

    assign hit_new  = hit[0];
    assign hit_pend = hit[1];
endmodule

// File: rtl/hrdo_event_slot.sv
// Holds the one event allowed per loop. It accepts the first event of a loop
// and flags later ones as overrun. It fires either the incoming event or the
// pending one when its phase hits. Anything unmatched is dropped at the next
// loop_start. Assumes loop_start is a one-cycle pulse on the first cycle of a
// loop.
module hrdo_event_slot #(
    parameter int HR_W = hrdo_pkg::HRDO_FIELD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loop_start,
    input  logic            evt_valid,
    input  logic            evt_level,
    input  logic [HR_W-1:0] new_dly,
    input  logic            hit_new,
    input  logic            hit_pend,
    output logic [HR_W-1:0] pend_dly,
    output logic            fire,
    output logic            fire_lvl,
    output logic            overrun
);
    logic acc_q;
    logic pend_v_q;
    logic pend_lvl_q;
    logic [HR_W-1:0] pend_dly_q;
    logic ovr_q;
    logic take;
    logic dup;
    logic fire_new;
    logic fire_pend;

    // Acceptance: a loop boundary reopens the slot in the same cycle.
    always_comb begin
        take      = evt_valid && (loop_start || !acc_q);
        dup       = evt_valid && !take;
        fire_new  = take && hit_new;
        fire_pend = pend_v_q && !loop_start && hit_pend;
        fire      = fire_new || fire_pend;
        fire_lvl  = fire_new ? evt_level : pend_lvl_q;
    end

    // Track whether this loop has already used its event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
        end else if (take) begin
            acc_q <= 1'b1;
        end else if (loop_start) begin
            acc_q <= 1'b0;
        end
    end

    // Pending event: load if not fired at once, drop at boundary or on fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q   <= 1'b0;
            pend_lvl_q <= 1'b0;
            pend_dly_q <= '0;
        end else if (take) begin
            pend_v_q   <= !hit_new;
            pend_lvl_q <= evt_level;
            pend_dly_q <= new_dly;
        end else if (loop_start || fire_pend) begin
            pend_v_q   <= 1'b0;
        end
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (dup) begin
            ovr_q <= 1'b1;
        end
    end

    assign pend_dly = pend_dly_q;
    assign overrun  = ovr_q;

    // R6
    dup_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !loop_start && acc_q) |=> ovr_q);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);

    // R8
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start && !evt_valid) |=> !pend_v_q);
endmodule

// File: rtl/hrdo_edge_reg.sv
// Registers the pin level: it takes the fired level on a fire edge and holds
// otherwise. Assumes fire is only asserted on HR tick edges.
module hrdo_edge_reg #(
    parameter logic PIN_INIT = hrdo_pkg::HRDO_PIN_INIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hr_en,
    input  logic fire,
    input  logic fire_lvl,
    output logic pin
);
    logic pin_q;

    // Pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= PIN_INIT;
        end else if (fire) begin
            pin_q <= fire_lvl;
        end
    end

    assign pin = pin_q;

    // R5
    pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hr_en |=> $stable(pin_q));

    // R2
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pin_q == $past(fire_lvl)));
endmodule

// File: rtl/hr_delay_out.sv
// High-resolution delayed compare output. It decodes the fractional delay of
// each loop's event, compares it with the HR phase, and drives one pin. Extra
// events within a loop are refused and latched as overrun.
// Assumes lr_log2 is constant within a loop and hr_phase < 2^lr_log2.
module hr_delay_out #(
    parameter int   HR_W     = hrdo_pkg::HRDO_FIELD_W,
    parameter int   LRL_W    = $clog2(HR_W + 1),
    parameter logic PIN_INIT = hrdo_pkg::HRDO_PIN_INIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hr_en,
    input  logic [HR_W-1:0]  hr_phase,
    input  logic [LRL_W-1:0] lr_log2,
    input  logic             loop_start,
    input  logic             evt_valid,
    input  logic             evt_level,
    input  logic [HR_W-1:0]  evt_delay,
    output logic             pin,
    output logic             overrun
);
    logic [HR_W-1:0] new_dly;
    logic [HR_W-1:0] pend_dly;
    logic hit_new;
    logic hit_pend;
    logic fire;
    logic fire_lvl;

    hrdo_field_decode #(.HR_W(HR_W), .LRL_W(LRL_W)) u_decode (
        .field   (evt_delay),
        .lr_log2 (lr_log2),
        .delay   (new_dly)
    );

    hrdo_phase_cmp #(.HR_W(HR_W)) u_cmp (
        .hr_en    (hr_en),
        .hr_phase (hr_phase),
        .new_dly  (new_dly),
        .pend_dly (pend_dly),
        .hit_new  (hit_new),
        .hit_pend (hit_pend)
    );

    hrdo_event_slot #(.HR_W(HR_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_start (loop_start),
        .evt_valid  (evt_valid),
        .evt_level  (evt_level),
        .new_dly    (new_dly),
        .hit_new    (hit_new),
        .hit_pend   (hit_pend),
        .pend_dly   (pend_dly),
        .fire       (fire),
        .fire_lvl   (fire_lvl),
        .overrun    (overrun)
    );

    hrdo_edge_reg #(.PIN_INIT(PIN_INIT)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .hr_en    (hr_en),
        .fire     (fire),
        .fire_lvl (fire_lvl),
        .pin      (pin)
    );

    // R3
    delay_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, new_dly} < ((HR_W+1)'(1) << lr_log2)));

    // R4
    lr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_log2 == '0) |-> (new_dly == '0));
endmodule

// File: tb/hr_delay_out_test.sv
// Bench for hr_delay_out: a behavioural model compared on every clock, plus
// scenario checks on edge timing.
module hr_delay_out_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hr_en = 1'b0;
    logic [6:0] hr_phase = '0;
    logic [2:0] lr_log2 = '0;
    logic       loop_start = 1'b0;
    logic       evt_valid = 1'b0;
    logic       evt_level = 1'b0;
    logic [6:0] evt_delay = '0;
    logic       pin;
    logic       overrun;

    always #4 clk = ~clk;

    hr_delay_out uut (
        .clk(clk), .rst_n(rst_n), .hr_en(hr_en), .hr_phase(hr_phase),
        .lr_log2(lr_log2), .loop_start(loop_start), .evt_valid(evt_valid),
        .evt_level(evt_level), .evt_delay(evt_delay), .pin(pin), .overrun(overrun)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string cur_req = "R1";

    // Behavioural model state.
    int m_pin = 0, m_ovr = 0, m_acc = 0, m_pend = 0, m_plvl = 0, m_pdly = 0;

    always @(posedge clk) begin
        int dly;
        int take;
        if (!rst_n) begin
            m_pin = 0; m_ovr = 0; m_acc = 0; m_pend = 0;
        end else begin
            dly  = int'(evt_delay) / (1 << (7 - int'(lr_log2)));
            take = (evt_valid && (loop_start || !m_acc)) ? 1 : 0;
            if (evt_valid && !take) m_ovr = 1;
            if (loop_start) m_pend = 0;
            if (m_pend && hr_en && int'(hr_phase) == m_pdly) begin
                m_pin = m_plvl; m_pend = 0;
            end
            if (take) begin
                m_acc = 1;
                if (hr_en && int'(hr_phase) == dly) m_pin = int'(evt_level);
                else begin m_pend = 1; m_plvl = int'(evt_level); m_pdly = dly; end
            end else if (loop_start) m_acc = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stimulus generator state.
    int div = 1, dcnt = 0, gphase = 0, gl = 7;

    task automatic tick();
        @(negedge clk);
        chk({cur_req, " pin"}, int'(pin), m_pin);
        chk({cur_req, " overrun"}, int'(overrun), m_ovr);
        evt_valid  = 1'b0;
        hr_en      = (dcnt == 0);
        loop_start = hr_en && (gphase == 0);
        hr_phase   = 7'(gphase);
        lr_log2    = 3'(gl);
        if (hr_en) gphase = (gphase + 1) % (1 << gl);
        dcnt = (dcnt + 1) % div;
    endtask

    task automatic setup(int l, int d);
        gl = l; div = d; gphase = 0; dcnt = 0;
    endtask

    task automatic to_loop_start();
        do tick(); while (!loop_start);
    endtask

    task automatic to_phase(int p);
        do tick(); while (!(hr_en && int'(hr_phase) == p));
    endtask

    task automatic ev(int lvl, int d);
        evt_valid = 1'b1; evt_level = lvl[0]; evt_delay = 7'(d);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        setup(7, 1);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 pin after reset", int'(pin), 0);
        chk("R1 overrun after reset", int'(overrun), 0);

        // R2 full 128-period loop
        cur_req = "R2";
        setup(7, 1);
        to_loop_start(); ev(1, 37);
        to_phase(37);
        chk("R2 before match", int'(pin), 0);
        tick();
        chk("R2 after match", int'(pin), 1);
        to_loop_start(); ev(0, 127);
        to_loop_start();
        chk("R2 delay 127", int'(pin), 0);
        ev(1, 0);
        tick();
        chk("R2 delay 0", int'(pin), 1);

        // R3 MSB-aligned field, low bits ignored
        cur_req = "R3";
        setup(4, 1);
        to_loop_start(); ev(0, 7'h5F);
        to_phase(11);
        chk("R3 lr16 before", int'(pin), 1);
        tick();
        chk("R3 lr16 at 11", int'(pin), 0);
        to_loop_start(); ev(1, 7'h58);
        to_phase(11);
        chk("R3 low bits clear before", int'(pin), 0);
        tick();
        chk("R3 low bits clear at 11", int'(pin), 1);
        setup(1, 1);
        to_loop_start(); ev(0, 7'h7F);
        tick();
        chk("R3 lr2 phase0", int'(pin), 1);
        tick();
        chk("R3 lr2 phase1", int'(pin), 0);

        // R4 single-period loop
        cur_req = "R4";
        setup(0, 1);
        to_loop_start(); ev(1, 7'h7F);
        tick();
        chk("R4 lr1 immediate", int'(pin), 1);
        ev(0, 7'h40);
        tick();
        chk("R4 lr1 second loop", int'(pin), 0);

        // R5 HR tick gating
        cur_req = "R5";
        setup(3, 2);
        to_loop_start(); ev(1, 7'h50);
        to_phase(5);
        chk("R5 not before tick", int'(pin), 0);
        tick();
        chk("R5 on tick", int'(pin), 1);
        to_loop_start();

        // R8 stale event dropped; R10 late first event applied
        cur_req = "R8";
        setup(7, 1);
        to_loop_start(); to_phase(50); ev(0, 10);
        to_loop_start();
        to_loop_start();
        chk("R8 stale dropped", int'(pin), 1);
        chk("R8 no overrun", int'(overrun), 0);
        cur_req = "R10";
        to_phase(20); ev(0, 90);
        to_loop_start();
        chk("R10 late event fired", int'(pin), 0);

        // R9 boundary reopens acceptance
        cur_req = "R9";
        to_loop_start(); ev(1, 5);
        to_loop_start(); ev(0, 5);
        to_loop_start();
        chk("R9 new loop accepted", int'(pin), 0);
        chk("R9 no overrun", int'(overrun), 0);

        // R6 second event in a loop ignored
        cur_req = "R6";
        to_loop_start(); ev(1, 100);
        to_phase(10); ev(0, 20);
        tick();
        chk("R6 overrun set", int'(overrun), 1);
        to_phase(60);
        chk("R6 second ignored", int'(pin), 0);
        to_loop_start();
        chk("R6 first applied", int'(pin), 1);

        // R7 sticky overrun
        cur_req = "R7";
        ev(0, 3);
        to_loop_start();
        to_loop_start();
        chk("R7 overrun kept", int'(overrun), 1);
        chk("R7 normal event still applies", int'(pin), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule